// File: doc/BRIEF.md
# Programmable reference divider path

This block prepares the reference timing for a phase/frequency detector. A slow reference arrives as an asynchronous level on `ref_in`. A fast system clock samples it through a two-flop synchronizer. A registered compare of successive samples then picks out the active reference edges. With `dbl_en` low only falling edges count. With `dbl_en` high both edges count, which doubles the effective reference rate.

The active edges feed a 10-bit programmable divider. It issues a one-clock terminal pulse once per `ratio` active edges. An optional halving stage follows the divider. When `half_en` is set, the halving stage toggles a square wave `pfd_half` on every terminal pulse. It also passes only every second terminal pulse to `pfd_strobe`, so the detector sees a 50% duty reference at half the rate. Two controls stop the path and return it to its starting state without touching the configuration inputs: `cnt_hold` (counter reset) and `pwr_dn` (power-down).

The divider is a two-state machine. DIV_HOLD moves to DIV_COUNT on the first clock with `cnt_hold` and `pwr_dn` both low. Any state moves to DIV_HOLD while either control is high. The halving stage is a two-state machine. PH_LOW goes to PH_HIGH on a terminal pulse while `half_en` is set. PH_HIGH goes back to PH_LOW on the next terminal pulse. PH_HIGH also drops to PH_LOW at once when `half_en` is low or the path is held.

Top module: `ref_div_path`

## Requirements
- R1: With `dbl_en`=0 only a high-to-low change of the synchronized reference is an active edge, and low-to-high changes are not counted.
- R2: With `dbl_en`=1 both high-to-low and low-to-high changes of the synchronized reference are active edges.
- R3: With `ratio`=N (1..1023) the divider emits exactly one terminal pulse for every N active edges, counted from zero after reset or a hold. Each `pfd_strobe` pulse is one clock wide, and a pulse occurs only after an active edge.
- R4: A `ratio` of 0 behaves exactly like a ratio of 1: every active edge is terminal.
- R5: A `ratio` change written while counting takes effect only after the next terminal count, which still uses the old ratio. After a hold, the ratio present on release is loaded.
- R6: With `half_en`=1, `pfd_half` toggles on each terminal pulse, giving a 50% duty square wave. `pfd_strobe` fires only on the terminal pulses that raise `pfd_half`. With `half_en`=0, `pfd_half` stays 0 and every terminal pulse reaches `pfd_strobe`.
- R7: While `cnt_hold`=1 no `pfd_strobe` pulse is produced and the edge count is cleared. Counting restarts from zero on release.
- R8: While `pwr_dn`=1 the path behaves as under R7 and `pfd_half` is forced to 0. After release, the configuration inputs are still in effect without any rewrite.
- R9: With the default parameters, take the first clock edge that samples a new `ref_in` level as edge 1. If that level change makes an active terminal edge, `pfd_strobe` is high after clock edge 5.
- R10: After reset `pfd_strobe`=0 and `pfd_half`=0, the synchronizer holds low and the divider starts in DIV_HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the reference |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous reference level |
| dbl_en | input | 1 | 1: both reference edges are active; 0: falling edge only |
| half_en | input | 1 | 1: enable the divide-by-2 toggle stage |
| ratio | input | 10 | Divider ratio, 0 treated as 1 |
| cnt_hold | input | 1 | Counter reset: holds the divider cleared |
| pwr_dn | input | 1 | Power-down: holds the divider and clears the toggle |
| pfd_strobe | output | 1 | One-clock reference strobe to the detector |
| pfd_half | output | 1 | 50% duty toggled reference (divide-by-2 mode) |

## Verification
A wrong edge count or a stale latched ratio first shows as a `pfd_strobe` pulse that is missing or extra. This appears at most one ratio's worth of active edges later, plus the fixed five-clock pipeline. A toggle stage in the wrong phase shows at once as an inverted `pfd_half` and strobes in the wrong half of the wave. The bench's clock-by-clock model exposes any such mismatch on the first clock it occurs. Strobe counts per scenario then tie each mismatch to the ratio rule it breaks.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;

    typedef enum logic [0:0] {
        DIV_HOLD  = 1'b0,
        DIV_COUNT = 1'b1
    } div_state_t;

    typedef enum logic [0:0] {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } half_state_t;

endpackage

// File: rtl/ref_edge_sel.sv
module ref_edge_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic dbl_en,
    output logic edge_q
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur_lvl;
    logic                   fall_seen;
    logic                   rise_seen;

    // synchronizer chain, one flop per stage
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= ref_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign cur_lvl   = sync_q[SYNC_STAGES-1];
    assign fall_seen = prev_q & ~cur_lvl;
    assign rise_seen = ~prev_q & cur_lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            prev_q <= cur_lvl;
            edge_q <= dbl_en ? (fall_seen | rise_seen) : fall_seen;
        end
    end

endmodule

// File: rtl/ref_ratio_div.sv
module ref_ratio_div
    import ref_div_pkg::*;
#(
    parameter int RATIO_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               edge_i,
    input  logic [RATIO_W-1:0] ratio,
    output logic               div_p
);

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    div_state_t         state_q;
    div_state_t         state_d;
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] lat_q;
    logic [RATIO_W-1:0] eff_ratio;
    logic               at_term;

    assign eff_ratio = (ratio == '0) ? ONE : ratio;
    assign at_term   = (cnt_q == (lat_q - ONE));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_HOLD:  state_d = hold ? DIV_HOLD : DIV_COUNT;
            DIV_COUNT: state_d = hold ? DIV_HOLD : DIV_COUNT;
            default:   state_d = DIV_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DIV_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lat_q <= ONE;
            div_p <= 1'b0;
        end else if (hold || state_q == DIV_HOLD) begin
            cnt_q <= '0;
            lat_q <= eff_ratio;
            div_p <= 1'b0;
        end else begin
            div_p <= edge_i & at_term;
            if (edge_i) begin
                if (at_term) begin
                    cnt_q <= '0;
                    lat_q <= eff_ratio;
                end else begin
                    cnt_q <= cnt_q + ONE;
                end
            end
        end
    end

endmodule

// File: rtl/ref_half_stage.sv
module ref_half_stage
    import ref_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic half_en,
    input  logic div_i,
    output logic strobe_o,
    output logic half_o
);

    half_state_t ph_q;
    half_state_t ph_d;

    always_comb begin
        ph_d = ph_q;
        if (hold || !half_en) begin
            ph_d = PH_LOW;
        end else begin
            unique case (ph_q)
                PH_LOW:  ph_d = div_i ? PH_HIGH : PH_LOW;
                PH_HIGH: ph_d = div_i ? PH_LOW : PH_HIGH;
                default: ph_d = PH_LOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_LOW;
        else        ph_q <= ph_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_o <= 1'b0;
        else        strobe_o <= ~hold & div_i & (~half_en | (ph_q == PH_LOW));
    end

    assign half_o = (ph_q == PH_HIGH);

endmodule

// File: rtl/ref_div_path.sv
module ref_div_path #(
    parameter int RATIO_W     = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_in,
    input  logic               dbl_en,
    input  logic               half_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               cnt_hold,
    input  logic               pwr_dn,
    output logic               pfd_strobe,
    output logic               pfd_half
);

    logic hold;
    logic edge_act;
    logic div_p;

    assign hold = cnt_hold | pwr_dn;

    ref_edge_sel #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .dbl_en (dbl_en),
        .edge_q (edge_act)
    );

    ref_ratio_div #(.RATIO_W(RATIO_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .edge_i (edge_act),
        .ratio  (ratio),
        .div_p  (div_p)
    );

    ref_half_stage u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .half_en  (half_en),
        .div_i    (div_p),
        .strobe_o (pfd_strobe),
        .half_o   (pfd_half)
    );

endmodule

// File: rtl/ref_div_path_chk.sv
module ref_div_path_chk (
    input logic clk,
    input logic rst_n,
    input logic cnt_hold,
    input logic pwr_dn,
    input logic half_en,
    input logic edge_act,
    input logic pfd_strobe,
    input logic pfd_half
);

    p_strobe_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pfd_strobe |-> $past(edge_act, 2));

    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_hold | pwr_dn) |-> !pfd_strobe);

    p_pd_clears_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_dn) |-> !pfd_half);

    p_half_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!half_en) |-> !pfd_half);

    p_half_strobe_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pfd_strobe && $past(half_en)) |-> (pfd_half && !$past(pfd_half)));

endmodule

bind ref_div_path ref_div_path_chk u_chk (.*);

// File: tb/tb_ref_div_path.sv
`timescale 1ns/1ps
module tb_ref_div_path;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b1;
    logic       dbl_en = 1'b0;
    logic       half_en = 1'b0;
    logic [9:0] ratio = 10'd3;
    logic       cnt_hold = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       pfd_strobe;
    logic       pfd_half;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    strb_cnt = 0;
    int    high_run = 0;
    int    last_high = 0;
    string tag = "R10";

    // behavioural model state
    logic m_s1, m_s2, m_s3, m_edge, m_run, m_div, m_q, m_strobe;
    int   m_cnt, m_lat;

    always #5 clk = ~clk;

    ref_div_path dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .dbl_en(dbl_en),
        .half_en(half_en), .ratio(ratio), .cnt_hold(cnt_hold),
        .pwr_dn(pwr_dn), .pfd_strobe(pfd_strobe), .pfd_half(pfd_half)
    );

    always @(posedge clk) begin
        logic hold, n_div, n_q, n_str, n_edge;
        int   eff;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_edge = 0; m_run = 0;
            m_div = 0; m_q = 0; m_strobe = 0; m_cnt = 0; m_lat = 1;
        end else begin
            hold = cnt_hold | pwr_dn;
            eff  = (ratio == 0) ? 1 : int'(ratio);
            n_str = 0;
            n_q   = m_q;
            if (hold) n_q = 0;
            else if (m_div) begin
                n_str = !half_en || !m_q;
                n_q   = half_en ? !m_q : 1'b0;
            end else if (!half_en) n_q = 0;
            n_div = 0;
            if (hold || !m_run) begin
                m_cnt = 0; m_lat = eff;
            end else if (m_edge) begin
                if (m_cnt == m_lat - 1) begin
                    n_div = 1; m_cnt = 0; m_lat = eff;
                end else m_cnt++;
            end
            m_run = !hold;
            n_edge = dbl_en ? (m_s2 != m_s3) : (m_s3 && !m_s2);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_in;
            m_edge = n_edge; m_div = n_div; m_q = n_q; m_strobe = n_str;
        end
    end

    task automatic check(input string t, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check({tag, " strobe"}, int'(pfd_strobe), int'(m_strobe));
            check({tag, " half"}, int'(pfd_half), int'(m_q));
            if (pfd_strobe) strb_cnt++;
            if (pfd_half) high_run++;
            else begin
                if (high_run != 0) last_high = high_run;
                high_run = 0;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic periods(input int n);
        for (int i = 0; i < n; i++) begin
            ref_in = 1'b0; idle(4);
            ref_in = 1'b1; idle(4);
        end
    endtask

    task automatic restart();
        cnt_hold = 1'b1; idle(3);
        cnt_hold = 1'b0; idle(3);
    endtask

    task automatic expect_strobes(input string t, input int base, input int exp);
        check(t, strb_cnt - base, exp);
    endtask

    initial begin
        #1_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base;
        int lat;
        idle(3);
        check("R10 reset strobe", int'(pfd_strobe), 0);
        check("R10 reset half", int'(pfd_half), 0);
        rst_n = 1'b1;
        idle(6);

        // R1 / R3: falling edges only, ratio 3
        tag = "R1"; base = strb_cnt;
        periods(12); idle(8);
        expect_strobes("R1 R3 ratio3 falling only", base, 4);

        // R2: both edges
        tag = "R2"; dbl_en = 1'b1; base = strb_cnt;
        periods(12); idle(8);
        expect_strobes("R2 both edges ratio3", base, 8);
        dbl_en = 1'b0;

        // R4: ratio 0 acts as 1
        tag = "R4"; ratio = 10'd0; restart(); base = strb_cnt;
        periods(5); idle(8);
        expect_strobes("R4 ratio0 as 1", base, 5);

        // R5: ratio change deferred to next terminal count
        tag = "R5"; ratio = 10'd5; restart(); base = strb_cnt;
        periods(2); ratio = 10'd2; periods(3); idle(8);
        expect_strobes("R5 old ratio finishes", base, 1);
        base = strb_cnt;
        periods(4); idle(8);
        expect_strobes("R5 new ratio after terminal", base, 2);

        // R7: counter reset clears and blocks
        tag = "R7"; ratio = 10'd3; restart(); periods(2);
        cnt_hold = 1'b1; base = strb_cnt;
        periods(6);
        expect_strobes("R7 no strobe while held", base, 0);
        cnt_hold = 1'b0; idle(3); base = strb_cnt;
        periods(2); idle(8);
        expect_strobes("R7 count restarted from zero", base, 0);
        periods(1); idle(8);
        expect_strobes("R7 third edge after release", base, 1);

        // R6: divide-by-2 toggle stage
        tag = "R6"; half_en = 1'b1; ratio = 10'd2; restart(); base = strb_cnt;
        periods(8); idle(8);
        expect_strobes("R6 every second terminal", base, 2);
        check("R6 half high run 50 percent", last_high, 16);

        // R8: power-down
        tag = "R8"; base = strb_cnt;
        periods(2); idle(8);
        expect_strobes("R8 strobe before power-down", base, 1);
        check("R8 half high before power-down", int'(pfd_half), 1);
        pwr_dn = 1'b1; idle(2);
        check("R8 half cleared by power-down", int'(pfd_half), 0);
        base = strb_cnt;
        periods(4);
        expect_strobes("R8 no strobe in power-down", base, 0);
        pwr_dn = 1'b0; idle(3); base = strb_cnt;
        periods(4); idle(8);
        expect_strobes("R8 config kept after power-down", base, 1);

        // R9: pipeline latency
        tag = "R9"; half_en = 1'b0; ratio = 10'd1; restart();
        lat = 0;
        ref_in = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            @(posedge clk); #1;
            if (pfd_strobe && lat == 0) lat = k;
        end
        check("R9 latency in clocks", lat, 5);
        ref_in = 1'b1; idle(8);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule